// File: doc/BRIEF.md
# Peripheral Byte Read Sequencer

This block moves bytes from an external asynchronous peripheral into an on-chip interface FIFO. Each byte is fetched with a fixed waveform on an active-low read strobe. A host first loads a 32-bit transaction count and then pulses start. The sequencer then performs one byte transaction per pass and decrements the count once per captured byte. It stops when the count reaches zero, when the host aborts, or when the peripheral reports that it has no data.

The states are IDLE, PROBE, STROBE, CAPTURE, TAIL and EMPTY. From IDLE, a start with a non-zero count leads to PROBE. A start with a zero count stays in IDLE and sets done. PROBE holds while the FIFO is full. When the FIFO has room, PROBE goes to EMPTY if the status input is low, and to STROBE otherwise. STROBE lasts a fixed number of cycles and then leads to CAPTURE. CAPTURE writes the byte into the FIFO and always leads to TAIL. TAIL goes to IDLE (setting done) if the count is now zero, and back to PROBE otherwise. EMPTY holds until an abort arrives. An abort in any state leads to IDLE.

The live count is visible on an output at all times. The host reads it to follow progress. An interrupt output is raised while the sequencer sits in EMPTY.

Top module: `prd_wave_engine`

## Requirements
- R1: After reset, the engine is idle and all outputs are inactive: `per_rd_n_o`=1, `fifo_wr_o`=0, `empty_irq_o`=0, `busy_o`=0, `done_o`=0, `xfer_count_o`=0.
- R2: A `host_cnt_load_i` pulse in IDLE copies `host_cnt_i` into the counter, and `xfer_count_o` shows the new value in the next cycle. A load while `busy_o`=1 is ignored.
- R3: Each transaction spends one PROBE cycle with `per_rd_n_o`=1. It then holds `per_rd_n_o`=0 for exactly 5 consecutive cycles: 3 STROBE cycles, 1 CAPTURE cycle and 1 TAIL cycle. A full pass therefore takes 6 cycles.
- R4: `fifo_wr_o` is high for exactly one cycle per transaction. That cycle is the fourth cycle of the low strobe. During it, `fifo_wdata_o` equals `per_data_i`. Bytes reach the FIFO in the order the peripheral presents them.
- R5: The count drops by one on each FIFO write. When TAIL ends with a count of zero, the engine returns to IDLE and `done_o` goes to 1. The next accepted start clears `done_o`.
- R6: If `per_stat_i`=0 (peripheral empty) in PROBE, the engine enters EMPTY. In EMPTY, `per_rd_n_o`=1 and `empty_irq_o`=1, and the engine stays there until an abort.
- R7: While `fifo_full_i`=1 in PROBE, the engine waits in PROBE and issues no strobe.
- R8: `host_abort_i` in any busy state returns the engine to IDLE in the next cycle. At that point `per_rd_n_o`=1, `empty_irq_o`=0 and `done_o` stays 0. The count keeps its value.
- R9: A start pulse while `busy_o`=1 is ignored. The run completes with its original number of transactions.
- R10: A start with a count of zero performs no transaction and sets `done_o` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| per_data_i | input | 8 | Peripheral data bus |
| per_stat_i | input | 1 | Peripheral status: 1 = holds data, 0 = empty |
| per_rd_n_o | output | 1 | Active-low peripheral read strobe |
| fifo_wdata_o | output | 8 | Byte written into the interface FIFO |
| fifo_wr_o | output | 1 | FIFO write enable, one cycle per byte |
| fifo_full_i | input | 1 | FIFO full flag |
| host_cnt_i | input | 32 | Transaction count value to load |
| host_cnt_load_i | input | 1 | Load pulse for the count (accepted in IDLE only) |
| host_start_i | input | 1 | Start pulse |
| host_abort_i | input | 1 | Abort pulse |
| xfer_count_o | output | 32 | Live remaining transaction count |
| busy_o | output | 1 | Engine is in a non-idle state |
| done_o | output | 1 | Last run ended because the count reached zero |
| empty_irq_o | output | 1 | Peripheral-empty event, held while in EMPTY |

## Verification
The bench measures every low-strobe run and the total busy time of a four-byte run. A design with the wrong dwell length, or one that skips PROBE between passes, gives a run length other than 5 or a busy time other than 24 cycles. The bench also fires an abort in the middle of a strobe and starts a run against a peripheral that empties after two bytes. A design that loses the abort, or that leaves EMPTY on its own, keeps strobing or drops the interrupt. Finally, the bench sends start and load pulses into a running transfer and holds the FIFO full before a run. A design that honours those pulses produces the wrong number of bytes or the wrong final count, and one that ignores the full flag strobes while the FIFO has no room.

// File: rtl/prd_pkg.sv
package prd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_PROBE   = 3'd1,
        ST_STROBE  = 3'd2,
        ST_CAPTURE = 3'd3,
        ST_TAIL    = 3'd4,
        ST_EMPTY   = 3'd5
    } prd_state_e;

endpackage

// File: rtl/prd_xfer_counter.sv
module prd_xfer_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_en_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             dec_en_i,
    output logic [CNT_W-1:0] count_o,
    output logic             zero_o
);

    logic [CNT_W-1:0] count_q;

    // the load is gated to IDLE by the caller, so it never meets a decrement
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (load_en_i) begin
            count_q <= load_val_i;
        end else if (dec_en_i && (count_q != '0)) begin
            count_q <= count_q - CNT_W'(1);
        end
    end

    assign count_o = count_q;
    assign zero_o  = (count_q == '0);

endmodule

// File: rtl/prd_dwell_timer.sv
module prd_dwell_timer #(
    parameter int LEN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    output logic last_o
);

    generate
        if (LEN <= 1) begin : g_single
            // a one-cycle dwell needs no storage
            assign last_o = en_i;
        end else begin : g_count
            localparam int W = $clog2(LEN);
            localparam logic [W-1:0] LAST = W'(LEN - 1);
            logic [W-1:0] tick_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    tick_q <= '0;
                end else if (!en_i || (tick_q == LAST)) begin
                    tick_q <= '0;
                end else begin
                    tick_q <= tick_q + W'(1);
                end
            end

            assign last_o = en_i && (tick_q == LAST);
        end
    endgenerate

endmodule

// File: rtl/prd_seq_fsm.sv
module prd_seq_fsm
    import prd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       abort_i,
    input  logic       fifo_full_i,
    input  logic       per_stat_i,
    input  logic       cnt_zero_i,
    input  logic       dwell_last_i,
    output prd_state_e state_o,
    output logic       rd_n_o,
    output logic       fifo_wr_o,
    output logic       irq_o,
    output logic       busy_o,
    output logic       done_o
);

    prd_state_e state_q, state_d;
    logic       done_q, done_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= done_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        done_d  = done_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i && !abort_i) begin
                    if (cnt_zero_i) begin
                        done_d = 1'b1;
                    end else begin
                        done_d  = 1'b0;
                        state_d = ST_PROBE;
                    end
                end
            end
            ST_PROBE: begin
                if (abort_i) begin
                    state_d = ST_IDLE;
                end else if (fifo_full_i) begin
                    state_d = ST_PROBE;
                end else if (!per_stat_i) begin
                    state_d = ST_EMPTY;
                end else begin
                    state_d = ST_STROBE;
                end
            end
            ST_STROBE: begin
                if (abort_i) begin
                    state_d = ST_IDLE;
                end else if (dwell_last_i) begin
                    state_d = ST_CAPTURE;
                end
            end
            ST_CAPTURE: begin
                state_d = abort_i ? ST_IDLE : ST_TAIL;
            end
            ST_TAIL: begin
                if (abort_i) begin
                    state_d = ST_IDLE;
                end else if (cnt_zero_i) begin
                    state_d = ST_IDLE;
                    done_d  = 1'b1;
                end else begin
                    state_d = ST_PROBE;
                end
            end
            ST_EMPTY: begin
                if (abort_i) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs (Moore)
    always_comb begin
        rd_n_o    = 1'b1;
        fifo_wr_o = 1'b0;
        irq_o     = 1'b0;
        busy_o    = 1'b1;
        unique case (state_q)
            ST_IDLE:    busy_o = 1'b0;
            ST_PROBE:   ;
            ST_STROBE:  rd_n_o = 1'b0;
            ST_CAPTURE: begin
                rd_n_o    = 1'b0;
                fifo_wr_o = 1'b1;
            end
            ST_TAIL:    rd_n_o = 1'b0;
            ST_EMPTY:   irq_o  = 1'b1;
            default:    busy_o = 1'b0;
        endcase
    end

    assign state_o = state_q;
    assign done_o  = done_q;

endmodule

// File: rtl/prd_wave_engine.sv
module prd_wave_engine
    import prd_pkg::*;
#(
    parameter int DATA_W        = 8,
    parameter int CNT_W         = 32,
    parameter int STROBE_CYCLES = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] per_data_i,
    input  logic              per_stat_i,
    output logic              per_rd_n_o,
    output logic [DATA_W-1:0] fifo_wdata_o,
    output logic              fifo_wr_o,
    input  logic              fifo_full_i,
    input  logic [CNT_W-1:0]  host_cnt_i,
    input  logic              host_cnt_load_i,
    input  logic              host_start_i,
    input  logic              host_abort_i,
    output logic [CNT_W-1:0]  xfer_count_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              empty_irq_o
);

    prd_state_e state;
    logic       cnt_zero;
    logic       dwell_last;
    logic       wr;
    logic       busy;

    prd_seq_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (host_start_i),
        .abort_i      (host_abort_i),
        .fifo_full_i  (fifo_full_i),
        .per_stat_i   (per_stat_i),
        .cnt_zero_i   (cnt_zero),
        .dwell_last_i (dwell_last),
        .state_o      (state),
        .rd_n_o       (per_rd_n_o),
        .fifo_wr_o    (wr),
        .irq_o        (empty_irq_o),
        .busy_o       (busy),
        .done_o       (done_o)
    );

    prd_dwell_timer #(
        .LEN (STROBE_CYCLES)
    ) u_dwell (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (state == ST_STROBE),
        .last_o (dwell_last)
    );

    prd_xfer_counter #(
        .CNT_W (CNT_W)
    ) u_count (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_en_i  (host_cnt_load_i && !busy),
        .load_val_i (host_cnt_i),
        .dec_en_i   (wr),
        .count_o    (xfer_count_o),
        .zero_o     (cnt_zero)
    );

    assign fifo_wr_o    = wr;
    assign fifo_wdata_o = per_data_i;
    assign busy_o       = busy;

endmodule

// File: rtl/prd_wave_engine_chk.sv
module prd_wave_engine_chk #(
    parameter int CNT_W         = 32,
    parameter int STROBE_CYCLES = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             per_rd_n_o,
    input logic             fifo_wr_o,
    input logic             fifo_full_i,
    input logic             host_abort_i,
    input logic [CNT_W-1:0] xfer_count_o,
    input logic             busy_o,
    input logic             empty_irq_o
);

    localparam int RUN = STROBE_CYCLES + 2;
    int unsigned low_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          low_run <= 0;
        else if (!per_rd_n_o) low_run <= low_run + 1;
        else                 low_run <= 0;
    end

    p_strobe_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(per_rd_n_o) && !$past(host_abort_i)) |-> (low_run == RUN));

    p_wr_in_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_wr_o |-> !per_rd_n_o);

    p_wr_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_wr_o |=> !fifo_wr_o);

    p_count_dec_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_wr_o |=> (xfer_count_o == $past(xfer_count_o) - 1));

    p_count_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !fifo_wr_o) |=> $stable(xfer_count_o));

    p_irq_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (empty_irq_o && !host_abort_i) |=> empty_irq_o);

    p_irq_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        empty_irq_o |-> per_rd_n_o);

    p_full_no_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(per_rd_n_o) |-> !$past(fifo_full_i));

    p_abort_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        host_abort_i |=> (per_rd_n_o && !busy_o && !empty_irq_o));

endmodule

bind prd_wave_engine prd_wave_engine_chk #(
    .CNT_W         (CNT_W),
    .STROBE_CYCLES (STROBE_CYCLES)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .per_rd_n_o   (per_rd_n_o),
    .fifo_wr_o    (fifo_wr_o),
    .fifo_full_i  (fifo_full_i),
    .host_abort_i (host_abort_i),
    .xfer_count_o (xfer_count_o),
    .busy_o       (busy_o),
    .empty_irq_o  (empty_irq_o)
);

// File: tb/prd_wave_engine_bench.sv
`timescale 1ns/1ps
module prd_wave_engine_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  per_data_i;
    logic        per_stat_i;
    logic        per_rd_n_o;
    logic [7:0]  fifo_wdata_o;
    logic        fifo_wr_o;
    logic        fifo_full_i = 1'b0;
    logic [31:0] host_cnt_i = '0;
    logic        host_cnt_load_i = 1'b0;
    logic        host_start_i = 1'b0;
    logic        host_abort_i = 1'b0;
    logic [31:0] xfer_count_o;
    logic        busy_o;
    logic        done_o;
    logic        empty_irq_o;

    always #10 clk = ~clk;

    prd_wave_engine u_prd_wave_engine (
        .clk             (clk),
        .rst_n           (rst_n),
        .per_data_i      (per_data_i),
        .per_stat_i      (per_stat_i),
        .per_rd_n_o      (per_rd_n_o),
        .fifo_wdata_o    (fifo_wdata_o),
        .fifo_wr_o       (fifo_wr_o),
        .fifo_full_i     (fifo_full_i),
        .host_cnt_i      (host_cnt_i),
        .host_cnt_load_i (host_cnt_load_i),
        .host_start_i    (host_start_i),
        .host_abort_i    (host_abort_i),
        .xfer_count_o    (xfer_count_o),
        .busy_o          (busy_o),
        .done_o          (done_o),
        .empty_irq_o     (empty_irq_o)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    // peripheral model: byte stream indexed by how many bytes were taken
    int unsigned src_idx = 0;
    int unsigned avail_lim = 32'hFFFF_FFFF;
    int unsigned exp_idx = 0;
    int unsigned wr_seen = 0;
    int unsigned low_cycles = 0;
    int          run_len = 0;
    bit          skip_run = 1'b0;
    logic [7:0]  exp_q[$];

    function automatic logic [7:0] src_byte(int unsigned i);
        return 8'((i * 37 + 11) ^ (i >> 3));
    endfunction

    assign per_data_i = src_byte(src_idx);
    assign per_stat_i = (src_idx < avail_lim);

    task automatic check(bit ok, string req, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // driver side of the scoreboard
    task automatic expect_bytes(int n);
        for (int k = 0; k < n; k++) begin
            exp_q.push_back(src_byte(exp_idx));
            exp_idx++;
        end
    endtask

    // monitor: FIFO writes and strobe run lengths
    always @(negedge clk) begin
        if (rst_n) begin
            if (fifo_wr_o) begin
                wr_seen++;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R4", "unexpected FIFO write", 1, 0);
                end else begin
                    logic [7:0] e;
                    e = exp_q.pop_front();
                    check(fifo_wdata_o == e, "R4", "FIFO byte", fifo_wdata_o, e);
                    check(!per_rd_n_o, "R4", "strobe low at write", per_rd_n_o, 0);
                    check(run_len == 3, "R4", "write position in strobe", run_len + 1, 4);
                end
                src_idx++;
            end
            if (!per_rd_n_o) begin
                run_len++;
                low_cycles++;
            end else begin
                if (run_len > 0 && !skip_run)
                    check(run_len == 5, "R3", "strobe low run", run_len, 5);
                if (run_len > 0) skip_run = 1'b0;
                run_len = 0;
            end
        end
    end

    task automatic pulse_load(logic [31:0] v);
        @(negedge clk);
        host_cnt_i = v;
        host_cnt_load_i = 1'b1;
        @(negedge clk);
        host_cnt_load_i = 1'b0;
    endtask

    task automatic pulse_start();
        @(negedge clk);
        host_start_i = 1'b1;
        @(negedge clk);
        host_start_i = 1'b0;
    endtask

    task automatic pulse_abort();
        @(negedge clk);
        skip_run = 1'b1;
        host_abort_i = 1'b1;
        @(negedge clk);
        host_abort_i = 1'b0;
    endtask

    task automatic wait_idle(string req);
        int n = 0;
        while (busy_o && n < 2000) begin
            @(negedge clk);
            n++;
        end
        check(!busy_o, req, "engine returned to idle", busy_o, 0);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        check(1'b0, "WDOG", "watchdog expired", 1, 0);
        finish_run();
    end

    initial begin
        int busy_n;
        int w0;
        int unsigned l0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(per_rd_n_o == 1'b1, "R1", "strobe in reset", per_rd_n_o, 1);
        check(fifo_wr_o == 1'b0, "R1", "fifo write in reset", fifo_wr_o, 0);
        check(empty_irq_o == 1'b0, "R1", "irq in reset", empty_irq_o, 0);
        check(busy_o == 1'b0 && done_o == 1'b0, "R1", "busy/done in reset", {busy_o, done_o}, 0);
        check(xfer_count_o == 0, "R1", "count in reset", xfer_count_o, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 load, R3 pass timing, R4 bytes, R5 done
        pulse_load(32'd4);
        check(xfer_count_o == 4, "R2", "loaded count", xfer_count_o, 4);
        expect_bytes(4);
        @(negedge clk);
        host_start_i = 1'b1;
        @(negedge clk);
        host_start_i = 1'b0;
        busy_n = 0;
        while (busy_o && busy_n < 200) begin
            busy_n++;
            @(negedge clk);
        end
        check(busy_n == 24, "R3", "busy cycles for 4 passes", busy_n, 24);
        check(done_o == 1'b1, "R5", "done after count hits zero", done_o, 1);
        check(xfer_count_o == 0, "R5", "final count", xfer_count_o, 0);
        check(exp_q.size() == 0, "R4", "all bytes delivered", exp_q.size(), 0);

        // R9 start while busy, R5 done cleared by start
        pulse_load(32'd3);
        expect_bytes(3);
        w0 = wr_seen;
        pulse_start();
        check(done_o == 1'b0, "R5", "done cleared by start", done_o, 0);
        repeat (4) @(negedge clk);
        pulse_start();
        wait_idle("R9");
        check(wr_seen - w0 == 3, "R9", "bytes with extra start", wr_seen - w0, 3);
        check(done_o == 1'b1, "R9", "done after run", done_o, 1);

        // R2 load while busy is ignored
        pulse_load(32'd2);
        expect_bytes(2);
        pulse_start();
        repeat (2) @(negedge clk);
        pulse_load(32'd100);
        wait_idle("R2");
        check(xfer_count_o == 0, "R2", "count after busy load", xfer_count_o, 0);
        check(exp_q.size() == 0, "R2", "bytes with busy load", exp_q.size(), 0);

        // R6 peripheral empties after two bytes
        avail_lim = src_idx + 2;
        pulse_load(32'd5);
        expect_bytes(2);
        pulse_start();
        repeat (30) @(negedge clk);
        check(empty_irq_o == 1'b1, "R6", "empty interrupt", empty_irq_o, 1);
        check(per_rd_n_o == 1'b1, "R6", "strobe released when empty", per_rd_n_o, 1);
        check(xfer_count_o == 3, "R6", "count at empty", xfer_count_o, 3);
        repeat (20) @(negedge clk);
        check(empty_irq_o && busy_o, "R6", "still parked in empty", {empty_irq_o, busy_o}, 3);
        pulse_abort();
        check(!busy_o && !empty_irq_o, "R8", "abort from empty", {busy_o, empty_irq_o}, 0);
        check(done_o == 1'b0, "R8", "no done after abort", done_o, 0);
        avail_lim = 32'hFFFF_FFFF;

        // R7 FIFO full holds in probe
        @(negedge clk);
        fifo_full_i = 1'b1;
        pulse_load(32'd1);
        expect_bytes(1);
        l0 = low_cycles;
        pulse_start();
        repeat (20) @(negedge clk);
        check(low_cycles == l0, "R7", "no strobe while full", low_cycles - l0, 0);
        check(busy_o == 1'b1, "R7", "waiting while full", busy_o, 1);
        fifo_full_i = 1'b0;
        wait_idle("R7");
        check(exp_q.size() == 0 && done_o, "R7", "byte after full released", exp_q.size(), 0);

        // R8 abort in the middle of a strobe
        pulse_load(32'd5);
        pulse_start();
        while (per_rd_n_o) @(negedge clk);
        @(negedge clk);
        skip_run = 1'b1;
        host_abort_i = 1'b1;
        @(negedge clk);
        host_abort_i = 1'b0;
        check(per_rd_n_o == 1'b1 && !busy_o, "R8", "abort mid-strobe", {per_rd_n_o, busy_o}, 2);
        check(done_o == 1'b0, "R8", "done after abort", done_o, 0);
        check(xfer_count_o == 5, "R8", "count kept on abort", xfer_count_o, 5);

        // R10 start with zero count
        pulse_load(32'd0);
        l0 = low_cycles;
        @(negedge clk);
        host_start_i = 1'b1;
        @(negedge clk);
        host_start_i = 1'b0;
        check(done_o == 1'b1 && !busy_o, "R10", "zero count start", {done_o, busy_o}, 2);
        repeat (10) @(negedge clk);
        check(low_cycles == l0, "R10", "no strobe on zero count", low_cycles - l0, 0);
        check(exp_q.size() == 0, "R4", "scoreboard empty at end", exp_q.size(), 0);

        finish_run();
    end

endmodule